// File: doc/BRIEF.md
# Whole-Cache Maintenance Engine

This block keeps the per-line state of a small data cache and runs whole-cache maintenance commands on it. Each line holds a tag, a data word, and two separate presence bits: one that marks it valid and clean, and one that marks it valid and dirty. A fill/write port loads lines as clean or marks them dirty. A read-side lookup port shows the state of any line without changing it.

Four commands are supported:

- **Write-back-and-invalidate** pushes out every dirty line and leaves the whole cache empty.
- **Write-back-and-keep** pushes out dirty lines and leaves them clean.
- **Drop-all** empties the cache without writing anything back. It needs the privilege input to be high.
- **Drop-clean** empties only the clean lines and keeps dirty lines intact.

The two drop commands act on all lines at once in a fixed short time. The two write-back commands walk the lines in ascending index order and present each dirty line on a valid/ready writeback channel. Typical use is the last step of a non-coherent DMA sequence. There, drop-clean removes stale copies of memory without the cost of a scan or any bus traffic.

Top module: `cache_maint_engine`

## Requirements
- R1: Opcode 0 (write-back-and-invalidate) presents every dirty line on the writeback channel in ascending index order, with its stored tag and data. When done pulses, no line is clean or dirty.
- R2: Opcode 1 (write-back-and-keep) presents every dirty line in ascending index order. After each accepted writeback, that line is clean with the same tag and data. Lines that were already clean or invalid are unchanged.
- R3: Opcode 2 (drop-all) with `priv_hi` = 1 clears every line, issues no writeback and raises no error.
- R4: Opcode 3 (drop-clean) clears every clean line and leaves dirty lines, with their tag and data, untouched. It issues no writeback, and this holds for either value of `priv_hi`.
- R5: Opcode 2 with `priv_hi` = 0 changes no line, issues no writeback, and raises `cmd_err` for exactly the one cycle in which `cmd_done` is high.
- R6: While `wb_valid` is high and `wb_ready` is low, the scan stalls. `wb_valid`, `wb_index`, `wb_tag` and `wb_data` hold their values until the transfer is accepted.
- R7: `cmd_busy` rises on the clock edge that accepts `cmd_start` and stays high through the single cycle in which `cmd_done` is high, then falls. `cmd_start` and fill/write requests seen while busy have no effect.
- R8: A fill with `fill_dirty` = 0 makes the line clean-valid. A fill with `fill_dirty` = 1 makes it dirty-valid. Both forms store the given tag and data. A line is never clean and dirty at once.
- R9: After reset, every line is invalid and `cmd_busy`, `cmd_done`, `cmd_err` and `wb_valid` are low.
- R10: Counted in clock edges after the accepting edge, `cmd_done` is visible after 1 edge for opcodes 2 and 3. For opcodes 0 and 1 it is visible after NUM_LINES + D edges, where D is the number of dirty lines, when `wb_ready` stays high. When the last line's writeback is stalled, `cmd_done` is visible right after the edge that accepts that writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start request, taken when not busy |
| cmd_op | input | 2 | Opcode: 0 write-back-and-invalidate, 1 write-back-and-keep, 2 drop-all, 3 drop-clean |
| priv_hi | input | 1 | Elevated privilege, sampled with the start |
| cmd_busy | output | 1 | Command in progress |
| cmd_done | output | 1 | One-cycle completion pulse |
| cmd_err | output | 1 | One-cycle refusal pulse, together with done |
| wb_valid | output | 1 | Writeback request valid |
| wb_ready | input | 1 | Writeback request accepted |
| wb_index | output | IDX_W | Line index of the writeback |
| wb_tag | output | TAG_W | Tag of the line written back |
| wb_data | output | DATA_W | Data of the line written back |
| fill_en | input | 1 | Fill/write request |
| fill_dirty | input | 1 | 0 loads clean, 1 marks dirty |
| fill_index | input | IDX_W | Line to fill or write |
| fill_tag | input | TAG_W | Tag to store |
| fill_data | input | DATA_W | Data to store |
| look_index | input | IDX_W | Line to observe |
| look_clean | output | 1 | Observed line is clean-valid |
| look_dirty | output | 1 | Observed line is dirty-valid |
| look_tag | output | TAG_W | Observed line tag |
| look_data | output | DATA_W | Observed line data |

## Verification
The hardest situation to reach from the ports is a stall on the last line, followed by a release and a check that done follows on the very next edge. A second hard case is a fill or start request that lands mid-scan. The bench builds the first with a cache whose only dirty line is the last one and holds `wb_ready` low for several cycles while it compares the channel values. For the second, it drives a fill to an invalid line and a privileged drop-all while busy. It then reads every line back through the lookup port to show that neither left a trace.

// File: rtl/cme_pkg.sv
// Shared types for the whole-cache maintenance engine.
// Assumes two-bit opcodes whose values are part of the block's interface.
package cme_pkg;

    typedef enum logic [1:0] {
        OP_WB_INV     = 2'd0,
        OP_WB_KEEP    = 2'd1,
        OP_DROP_ALL   = 2'd2,
        OP_DROP_CLEAN = 2'd3
    } maint_op_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_BULK = 3'd1,
        ST_SCAN = 3'd2,
        ST_WB   = 3'd3,
        ST_DONE = 3'd4
    } eng_state_e;

    typedef enum logic [1:0] {
        UPD_NONE     = 2'd0,
        UPD_INVAL    = 2'd1,
        UPD_TO_CLEAN = 2'd2
    } line_upd_e;

endpackage

// File: rtl/cme_line_store.sv
// Per-line state of the cache: clean-valid bit, dirty-valid bit, tag, data.
// Supports a fill/write, a single-line update from the scan, and bulk clears
// of all clean bits and/or all dirty bits in one cycle. Two read ports.
// Assumes the caller never requests a fill together with an update or bulk clear.
module cme_line_store
    import cme_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 8,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fill_en,
    input  logic                 fill_dirty,
    input  logic [IDX_W-1:0]     fill_idx,
    input  logic [TAG_W-1:0]     fill_tag,
    input  logic [DATA_W-1:0]    fill_data,
    input  line_upd_e            upd_kind,
    input  logic [IDX_W-1:0]     upd_idx,
    input  logic                 bulk_clr_clean,
    input  logic                 bulk_clr_dirty,
    input  logic [IDX_W-1:0]     scan_idx,
    output logic                 scan_clean,
    output logic                 scan_dirty,
    output logic [TAG_W-1:0]     scan_tag,
    output logic [DATA_W-1:0]    scan_data,
    input  logic [IDX_W-1:0]     look_idx,
    output logic                 look_clean,
    output logic                 look_dirty,
    output logic [TAG_W-1:0]     look_tag,
    output logic [DATA_W-1:0]    look_data,
    output logic [NUM_LINES-1:0] clean_vec,
    output logic [NUM_LINES-1:0] dirty_vec
);

    logic [TAG_W-1:0]  tag_arr  [NUM_LINES];
    logic [DATA_W-1:0] data_arr [NUM_LINES];

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        logic              cv_q;
        logic              dv_q;
        logic [TAG_W-1:0]  tag_q;
        logic [DATA_W-1:0] data_q;
        logic              hit_fill;
        logic              hit_upd;

        assign hit_fill = fill_en && (fill_idx == IDX_W'(i));
        assign hit_upd  = (upd_idx == IDX_W'(i));

        // Presence bits: fill wins, else update and bulk clears.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cv_q <= 1'b0;
                dv_q <= 1'b0;
            end else if (hit_fill) begin
                cv_q <= !fill_dirty;
                dv_q <= fill_dirty;
            end else if (hit_upd && upd_kind == UPD_TO_CLEAN) begin
                cv_q <= 1'b1;
                dv_q <= 1'b0;
            end else begin
                if (bulk_clr_clean || (hit_upd && upd_kind == UPD_INVAL)) cv_q <= 1'b0;
                if (bulk_clr_dirty || (hit_upd && upd_kind == UPD_INVAL)) dv_q <= 1'b0;
            end
        end

        // Tag and data are written only by a fill.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q  <= '0;
                data_q <= '0;
            end else if (hit_fill) begin
                tag_q  <= fill_tag;
                data_q <= fill_data;
            end
        end

        assign clean_vec[i] = cv_q;
        assign dirty_vec[i] = dv_q;
        assign tag_arr[i]   = tag_q;
        assign data_arr[i]  = data_q;
    end

    // Scan-side read port.
    always_comb begin
        scan_clean = clean_vec[scan_idx];
        scan_dirty = dirty_vec[scan_idx];
        scan_tag   = tag_arr[scan_idx];
        scan_data  = data_arr[scan_idx];
    end

    // Lookup read port.
    always_comb begin
        look_clean = clean_vec[look_idx];
        look_dirty = dirty_vec[look_idx];
        look_tag   = tag_arr[look_idx];
        look_data  = data_arr[look_idx];
    end

endmodule

// File: rtl/cme_ctrl.sv
// Command sequencer: accepts a start, runs either a one-cycle bulk clear or
// an ascending line scan with a valid/ready writeback, then pulses done.
// Assumes the line store reads combinationally at scan_idx.
module cme_ctrl
    import cme_pkg::*;
#(
    parameter int NUM_LINES = 8,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_start,
    input  logic [1:0]       cmd_op,
    input  logic             priv_hi,
    input  logic             scan_clean,
    input  logic             scan_dirty,
    input  logic             wb_ready,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic             wb_valid,
    output logic [IDX_W-1:0] scan_idx,
    output line_upd_e        upd_kind,
    output logic             bulk_clr_clean,
    output logic             bulk_clr_dirty
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

    eng_state_e       state_q, state_d;
    maint_op_e        op_q, op_d;
    logic             deny_q, deny_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             at_last;
    maint_op_e        req_op;

    assign req_op  = maint_op_e'(cmd_op);
    assign at_last = (idx_q == LAST_IDX);

    // Next-state, line-update and bulk-clear decisions.
    always_comb begin
        state_d        = state_q;
        op_d           = op_q;
        deny_d         = deny_q;
        idx_d          = idx_q;
        upd_kind       = UPD_NONE;
        bulk_clr_clean = 1'b0;
        bulk_clr_dirty = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cmd_start) begin
                    op_d   = req_op;
                    deny_d = (req_op == OP_DROP_ALL) && !priv_hi;
                    idx_d  = '0;
                    if (req_op == OP_DROP_ALL || req_op == OP_DROP_CLEAN) state_d = ST_BULK;
                    else                                                   state_d = ST_SCAN;
                end
            end
            ST_BULK: begin
                if (!deny_q) begin
                    bulk_clr_clean = 1'b1;
                    bulk_clr_dirty = (op_q == OP_DROP_ALL);
                end
                state_d = ST_DONE;
            end
            ST_SCAN: begin
                if (scan_dirty) begin
                    state_d = ST_WB;
                end else begin
                    if (op_q == OP_WB_INV && scan_clean) upd_kind = UPD_INVAL;
                    if (at_last) state_d = ST_DONE;
                    else         idx_d   = idx_q + 1'b1;
                end
            end
            ST_WB: begin
                if (wb_ready) begin
                    upd_kind = (op_q == OP_WB_INV) ? UPD_INVAL : UPD_TO_CLEAN;
                    if (at_last) begin
                        state_d = ST_DONE;
                    end else begin
                        idx_d   = idx_q + 1'b1;
                        state_d = ST_SCAN;
                    end
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            op_q    <= OP_WB_INV;
            deny_q  <= 1'b0;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            deny_q  <= deny_d;
            idx_q   <= idx_d;
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_DONE);
    assign err      = done && deny_q;
    assign wb_valid = (state_q == ST_WB);
    assign scan_idx = idx_q;

endmodule

// File: rtl/cache_maint_engine.sv
// Top of the whole-cache maintenance engine: line store plus sequencer.
// Fill/write requests are blocked while a command runs. The writeback channel
// reads the line under the scan pointer, which does not move while stalled.
module cache_maint_engine
    import cme_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 8,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_op,
    input  logic              priv_hi,
    output logic              cmd_busy,
    output logic              cmd_done,
    output logic              cmd_err,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [IDX_W-1:0]  wb_index,
    output logic [TAG_W-1:0]  wb_tag,
    output logic [DATA_W-1:0] wb_data,
    input  logic              fill_en,
    input  logic              fill_dirty,
    input  logic [IDX_W-1:0]  fill_index,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic [DATA_W-1:0] fill_data,
    input  logic [IDX_W-1:0]  look_index,
    output logic              look_clean,
    output logic              look_dirty,
    output logic [TAG_W-1:0]  look_tag,
    output logic [DATA_W-1:0] look_data
);

    logic                 scan_clean;
    logic                 scan_dirty;
    logic [IDX_W-1:0]     scan_idx;
    line_upd_e            upd_kind;
    logic                 bulk_clr_clean;
    logic                 bulk_clr_dirty;
    logic                 fill_gated;
    logic [NUM_LINES-1:0] clean_vec;
    logic [NUM_LINES-1:0] dirty_vec;

    // Fills are only honoured while idle.
    assign fill_gated = fill_en && !cmd_busy;
    assign wb_index   = scan_idx;

    cme_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cmd_start      (cmd_start),
        .cmd_op         (cmd_op),
        .priv_hi        (priv_hi),
        .scan_clean     (scan_clean),
        .scan_dirty     (scan_dirty),
        .wb_ready       (wb_ready),
        .busy           (cmd_busy),
        .done           (cmd_done),
        .err            (cmd_err),
        .wb_valid       (wb_valid),
        .scan_idx       (scan_idx),
        .upd_kind       (upd_kind),
        .bulk_clr_clean (bulk_clr_clean),
        .bulk_clr_dirty (bulk_clr_dirty)
    );

    cme_line_store #(
        .NUM_LINES (NUM_LINES),
        .TAG_W     (TAG_W),
        .DATA_W    (DATA_W)
    ) u_store (
        .clk            (clk),
        .rst_n          (rst_n),
        .fill_en        (fill_gated),
        .fill_dirty     (fill_dirty),
        .fill_idx       (fill_index),
        .fill_tag       (fill_tag),
        .fill_data      (fill_data),
        .upd_kind       (upd_kind),
        .upd_idx        (scan_idx),
        .bulk_clr_clean (bulk_clr_clean),
        .bulk_clr_dirty (bulk_clr_dirty),
        .scan_idx       (scan_idx),
        .scan_clean     (scan_clean),
        .scan_dirty     (scan_dirty),
        .scan_tag       (wb_tag),
        .scan_data      (wb_data),
        .look_idx       (look_index),
        .look_clean     (look_clean),
        .look_dirty     (look_dirty),
        .look_tag       (look_tag),
        .look_data      (look_data),
        .clean_vec      (clean_vec),
        .dirty_vec      (dirty_vec)
    );

endmodule

// File: rtl/cme_checker.sv
// Protocol and state checks for the maintenance engine, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module cme_checker #(
    parameter int NUM_LINES = 8,
    parameter int TAG_W     = 8,
    parameter int DATA_W    = 32,
    localparam int IDX_W    = $clog2(NUM_LINES)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_start,
    input logic                 cmd_busy,
    input logic                 cmd_done,
    input logic                 cmd_err,
    input logic                 wb_valid,
    input logic                 wb_ready,
    input logic [IDX_W-1:0]     wb_index,
    input logic [TAG_W-1:0]     wb_tag,
    input logic [DATA_W-1:0]    wb_data,
    input logic [NUM_LINES-1:0] clean_vec,
    input logic [NUM_LINES-1:0] dirty_vec
);

    assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_index) && $stable(wb_tag) && $stable(wb_data));

    assert_done_in_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> cmd_busy);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done && !cmd_busy);

    assert_busy_on_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_busy && cmd_start |=> cmd_busy);

    assert_err_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> cmd_done);

    assert_wb_only_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> cmd_busy && !cmd_done);

    assert_line_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clean_vec & dirty_vec) == '0);

endmodule

bind cache_maint_engine cme_checker #(
    .NUM_LINES (NUM_LINES),
    .TAG_W     (TAG_W),
    .DATA_W    (DATA_W)
) u_cme_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .cmd_busy  (cmd_busy),
    .cmd_done  (cmd_done),
    .cmd_err   (cmd_err),
    .wb_valid  (wb_valid),
    .wb_ready  (wb_ready),
    .wb_index  (wb_index),
    .wb_tag    (wb_tag),
    .wb_data   (wb_data),
    .clean_vec (clean_vec),
    .dirty_vec (dirty_vec)
);

// File: tb/tb_cache_maint_engine.sv
`timescale 1ns/1ps
module tb_cache_maint_engine;

    localparam int NL = 8;
    localparam int TW = 8;
    localparam int DW = 32;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_start = 1'b0;
    logic [1:0]    cmd_op = 2'd0;
    logic          priv_hi = 1'b0;
    logic          cmd_busy, cmd_done, cmd_err, wb_valid;
    logic          wb_ready = 1'b1;
    logic [IW-1:0] wb_index;
    logic [TW-1:0] wb_tag;
    logic [DW-1:0] wb_data;
    logic          fill_en = 1'b0;
    logic          fill_dirty = 1'b0;
    logic [IW-1:0] fill_index = '0;
    logic [TW-1:0] fill_tag = '0;
    logic [DW-1:0] fill_data = '0;
    logic [IW-1:0] look_index = '0;
    logic          look_clean, look_dirty;
    logic [TW-1:0] look_tag;
    logic [DW-1:0] look_data;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    cache_maint_engine #(.NUM_LINES(NL), .TAG_W(TW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .priv_hi(priv_hi), .cmd_busy(cmd_busy), .cmd_done(cmd_done),
        .cmd_err(cmd_err), .wb_valid(wb_valid), .wb_ready(wb_ready),
        .wb_index(wb_index), .wb_tag(wb_tag), .wb_data(wb_data),
        .fill_en(fill_en), .fill_dirty(fill_dirty), .fill_index(fill_index),
        .fill_tag(fill_tag), .fill_data(fill_data), .look_index(look_index),
        .look_clean(look_clean), .look_dirty(look_dirty),
        .look_tag(look_tag), .look_data(look_data)
    );

    // Line code per entry: 2 bits per line, line 0 lowest; 0 invalid, 1 clean, 2 dirty.
    typedef struct packed {
        logic [15:0] init;
        logic [1:0]  op;
        logic        priv;
        logic [15:0] fin;
        logic [4:0]  nwb;
        logic [5:0]  edges;
        logic        err;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VT [NV] = '{
        '{16'h8589, 2'd0, 1'b0, 16'h0000, 5'd3, 6'd11, 1'b0},
        '{16'h8589, 2'd1, 1'b0, 16'h4545, 5'd3, 6'd11, 1'b0},
        '{16'h8589, 2'd2, 1'b1, 16'h0000, 5'd0, 6'd1,  1'b0},
        '{16'h8589, 2'd3, 1'b0, 16'h8088, 5'd0, 6'd1,  1'b0},
        '{16'h8589, 2'd2, 1'b0, 16'h8589, 5'd0, 6'd1,  1'b1},
        '{16'hAAAA, 2'd0, 1'b1, 16'h0000, 5'd8, 6'd16, 1'b0},
        '{16'h5555, 2'd1, 1'b0, 16'h5555, 5'd0, 6'd8,  1'b0},
        '{16'h0000, 2'd3, 1'b1, 16'h0000, 5'd0, 6'd1,  1'b0},
        '{16'hAAAA, 2'd3, 1'b0, 16'hAAAA, 5'd0, 6'd1,  1'b0},
        '{16'h5555, 2'd0, 1'b0, 16'h0000, 5'd0, 6'd8,  1'b0}
    };

    int            b_cnt;
    int            b_idx  [32];
    logic [TW-1:0] b_tag  [32];
    logic [DW-1:0] b_data [32];

    function automatic logic [DW-1:0] line_data(int v, int i);
        return 32'hC0DE_0000 | DW'(v << 8) | DW'(i);
    endfunction

    function automatic string op_req(logic [1:0] op, logic priv);
        case (op)
            2'd0: return "R1";
            2'd1: return "R2";
            2'd2: return priv ? "R3" : "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic fill(input int idx, input bit dirty, input logic [TW-1:0] t, input logic [DW-1:0] d);
        @(negedge clk);
        fill_en = 1'b1; fill_dirty = dirty; fill_index = IW'(idx);
        fill_tag = t; fill_data = d;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    // Issue a command and wait for done; records writeback beats.
    task automatic run_op(input logic [1:0] op, input logic priv,
                          output int edges, output bit err_seen);
        @(negedge clk);
        cmd_start = 1'b1; cmd_op = op; priv_hi = priv;
        @(posedge clk);
        @(negedge clk);
        cmd_start = 1'b0;
        edges = 0;
        b_cnt = 0;
        while (!cmd_done && edges < 200) begin
            if (wb_valid && wb_ready && b_cnt < 32) begin
                b_idx[b_cnt] = int'(wb_index);
                b_tag[b_cnt] = wb_tag;
                b_data[b_cnt] = wb_data;
                b_cnt++;
            end
            @(posedge clk);
            edges++;
            @(negedge clk);
        end
        err_seen = cmd_err;
    endtask

    task automatic clear_all();
        int e;
        bit r;
        run_op(2'd2, 1'b1, e, r);
    endtask

    task automatic line_code(input int idx, output logic [1:0] code);
        look_index = IW'(idx);
        #1;
        code = {look_dirty, look_clean};
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int edges;
        bit errs;
        logic [1:0] code;
        logic [TW-1:0] t0;
        logic [DW-1:0] d0;
        logic [IW-1:0] i0;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        chk(!cmd_busy && !cmd_done && !cmd_err && !wb_valid, "R9", "outputs after reset",
            {cmd_busy, cmd_done, cmd_err, wb_valid}, 0);
        for (int i = 0; i < NL; i++) begin
            line_code(i, code);
            chk(code == 2'b00, "R9", "line after reset", code, 0);
        end

        // Table walk
        for (int v = 0; v < NV; v++) begin
            int k;
            clear_all();
            for (int i = 0; i < NL; i++) begin
                logic [1:0] c;
                c = VT[v].init[2*i +: 2];
                if (c != 2'b00) fill(i, c == 2'b10, TW'(8'h30 + i), line_data(v, i));
            end
            wb_ready = 1'b1;
            run_op(VT[v].op, VT[v].priv, edges, errs);
            chk(edges == int'(VT[v].edges), "R10", $sformatf("done timing vec %0d", v), edges, VT[v].edges);
            chk(b_cnt == int'(VT[v].nwb), op_req(VT[v].op, VT[v].priv), $sformatf("writeback count vec %0d", v), b_cnt, VT[v].nwb);
            chk(errs == VT[v].err, op_req(VT[v].op, VT[v].priv), $sformatf("error vec %0d", v), errs, VT[v].err);
            k = 0;
            for (int i = 0; i < NL; i++) begin
                if (VT[v].init[2*i +: 2] == 2'b10 && k < b_cnt && VT[v].nwb != 0) begin
                    chk(b_idx[k] == i && b_tag[k] == TW'(8'h30 + i) && b_data[k] == line_data(v, i),
                        op_req(VT[v].op, VT[v].priv), $sformatf("writeback beat %0d vec %0d", k, v),
                        b_data[k], line_data(v, i));
                    k++;
                end
            end
            for (int i = 0; i < NL; i++) begin
                line_code(i, code);
                chk(code == VT[v].fin[2*i +: 2], op_req(VT[v].op, VT[v].priv),
                    $sformatf("line %0d state vec %0d", i, v), code, VT[v].fin[2*i +: 2]);
                if (code != 2'b00)
                    chk(look_tag == TW'(8'h30 + i) && look_data == line_data(v, i),
                        op_req(VT[v].op, VT[v].priv), $sformatf("line %0d content vec %0d", i, v),
                        look_data, line_data(v, i));
            end
        end

        // R8: fill clean then write dirty
        clear_all();
        fill(5, 1'b0, 8'h55, 32'h1111_2222);
        line_code(5, code);
        chk(code == 2'b01 && look_tag == 8'h55 && look_data == 32'h1111_2222, "R8", "clean fill", code, 2'b01);
        fill(5, 1'b1, 8'h55, 32'h3333_4444);
        line_code(5, code);
        chk(code == 2'b10 && look_data == 32'h3333_4444, "R8", "dirty write", code, 2'b10);

        // R6 / R10: stall on the last line, then release
        clear_all();
        fill(NL - 1, 1'b1, 8'h77, 32'hFACE_0007);
        fill(0, 1'b0, 8'h70, 32'hFACE_0000);
        wb_ready = 1'b0;
        @(negedge clk);
        cmd_start = 1'b1; cmd_op = 2'd1; priv_hi = 1'b0;
        @(negedge clk);
        cmd_start = 1'b0;
        edges = 0;
        while (!wb_valid && edges < 50) begin
            @(negedge clk);
            edges++;
        end
        i0 = wb_index; t0 = wb_tag; d0 = wb_data;
        chk(i0 == IW'(NL - 1) && t0 == 8'h77 && d0 == 32'hFACE_0007, "R6", "stalled request content", d0, 32'hFACE_0007);
        for (int s = 0; s < 5; s++) begin
            @(negedge clk);
            chk(wb_valid && !cmd_done && wb_index == i0 && wb_tag == t0 && wb_data == d0,
                "R6", "held during stall", wb_data, d0);
        end
        wb_ready = 1'b1;
        @(negedge clk);
        chk(cmd_done && !wb_valid, "R10", "done right after last accept", cmd_done, 1);
        wb_ready = 1'b1;
        @(negedge clk);
        line_code(NL - 1, code);
        chk(code == 2'b01 && look_tag == 8'h77 && look_data == 32'hFACE_0007, "R2", "last line kept clean", code, 2'b01);
        line_code(0, code);
        chk(code == 2'b01, "R2", "clean line unchanged", code, 2'b01);

        // R7: start and fill during busy are ignored
        clear_all();
        fill(0, 1'b0, 8'h80, 32'hBEEF_0000);
        fill(1, 1'b1, 8'h81, 32'hBEEF_0001);
        @(negedge clk);
        cmd_start = 1'b1; cmd_op = 2'd1; priv_hi = 1'b0;
        @(negedge clk);
        chk(cmd_busy, "R7", "busy after accept", cmd_busy, 1);
        cmd_start = 1'b1; cmd_op = 2'd2; priv_hi = 1'b1;
        fill_en = 1'b1; fill_dirty = 1'b1; fill_index = 3'd4; fill_tag = 8'h84; fill_data = 32'hDEAD_0004;
        @(negedge clk);
        cmd_start = 1'b0; fill_en = 1'b0;
        edges = 0;
        while (!cmd_done && edges < 50) begin
            chk(cmd_busy, "R7", "busy held until done", cmd_busy, 1);
            @(negedge clk);
            edges++;
        end
        @(negedge clk);
        chk(!cmd_busy && !cmd_done, "R7", "idle after done", {cmd_busy, cmd_done}, 0);
        line_code(4, code);
        chk(code == 2'b00, "R7", "fill while busy ignored", code, 0);
        line_code(0, code);
        chk(code == 2'b01, "R7", "start while busy ignored (line 0)", code, 2'b01);
        line_code(1, code);
        chk(code == 2'b01 && look_data == 32'hBEEF_0001, "R7", "start while busy ignored (line 1)", code, 2'b01);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule